// File: doc/BRIEF.md
# Parallel NAND Flash Device-Side Bus Interface

This block models the device end of a parallel NAND flash bus for use inside a larger chip. A host drives a chip select, a command latch, an address latch, a write strobe, a read strobe and a write-guard input, and exchanges bytes on an 8-bit or 16-bit data bus. All of these inputs are asynchronous. They are synchronised into one system clock, and the write and read strobes are edge-detected there, so every state change happens in that single clock domain.

A captured byte is routed by the latch levels that are present when the write strobe rises. A byte taken with the command latch high is decoded as an opcode. A byte taken with the address latch high loads the column counter. Any other byte is page data. A small page buffer made of registers stands in for the array. A countdown timer stands in for the busy time of the array-to-buffer read, of program and of erase. During that busy time the `ready` output is low.

The block recognises five opcodes:

- 0x00 starts a read. It takes one address byte.
- 0x80 opens a program load.
- 0x10 confirms a program.
- 0x60 opens an erase.
- 0xD0 confirms an erase.

Top module: `nand_dev_if`

## Requirements
- R1: On a rising write strobe with `sel_n` low, a byte taken with `cmd_lat` high is decoded as an opcode. A byte taken with `adr_lat` high loads the column counter from `bus_in[COL_W-1:0]`. Any other byte is stored as a page word at the column counter while a program load is open.
- R2: In the read output phase, each falling read strobe puts the page word at the column counter onto `bus_out` and then advances the counter by one. The counter wraps from the last column to column 0.
- R3: `ready` is low for the configured number of clocks after an erase confirm, a program confirm, or the address byte that follows a read opcode. At all other times `ready` is high.
- R4: `bus_oe` is high only in the read output phase while `sel_n` is low. It is low in reset, and low while `ready` is low.
- R5: While `guard_n` is low, the opcodes 0x80, 0x10, 0x60 and 0xD0 are rejected. No busy period starts, and the following data bytes leave the page unchanged.
- R6: A high `sel_n` during a program or erase busy period is ignored. The operation runs to completion.
- R7: A high `sel_n` during a read busy period ends the read at once, and the block returns to idle. When `SEL_DONT_CARE` is set, the read instead completes and its data can be read out.
- R8: Any byte captured before `PWRUP_CYC` clocks have passed since reset is ignored.
- R9: The page holds all ones after reset. An accepted erase sets every page word to all ones.
- R10: Opcode 0x80 resets the column to 0. Any opcode other than the five listed returns the block to idle, which closes an open program load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Chip select, active low (asynchronous) |
| cmd_lat | input | 1 | Command latch level (asynchronous) |
| adr_lat | input | 1 | Address latch level (asynchronous) |
| wstb_n | input | 1 | Write strobe; a byte is captured on its rising edge |
| rstb_n | input | 1 | Read strobe; each falling edge steps the data out |
| guard_n | input | 1 | Write guard; low blocks program and erase |
| bus_in | input | BUS_W | Data bus from the host |
| bus_out | output | BUS_W | Data bus to the host |
| bus_oe | output | 1 | Output enable for `bus_out` |
| ready | output | 1 | Low while an internal operation is busy |

## Verification
Some properties are checked by assertions on every clock:

- The output enable is never high while the block is busy.
- A rejected guarded opcode never opens a load, wait or busy state.
- Program busy holds its state until the timer ends.
- A read abort releases `ready` on the next cycle.
- Each read step advances the column by exactly one.
- The state stays idle until power-up recovery has passed.
- An erase fill leaves the buffer at all ones.

Other behaviour can only be shown by the bench scenarios. These cover the data that comes back after program and read, column wrap, guard and opcode rejection as seen through later reads, and the difference between the abort setting and the don't-care setting.

// File: rtl/nand_dev_pkg.sv
package nand_dev_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ADDR,
    ST_RD_BUSY,
    ST_RD_OUT,
    ST_PG_LOAD,
    ST_PG_BUSY,
    ST_ER_WAIT,
    ST_ER_BUSY
  } dev_state_e;

  localparam logic [7:0] OP_READ     = 8'h00;
  localparam logic [7:0] OP_PROG     = 8'h80;
  localparam logic [7:0] OP_PROG_GO  = 8'h10;
  localparam logic [7:0] OP_ERASE    = 8'h60;
  localparam logic [7:0] OP_ERASE_GO = 8'hD0;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] sh_q;
    logic [1:0] sh_n;

    always_comb begin
      sh_n = {sh_q[0], async_i[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= {2{RST_VAL[i]}};
      else        sh_q <= sh_n;
    end

    assign sync_o[i] = sh_q[1];
  end

endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,
  input  logic          abort_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_n  = cnt_q;
    cnt_en = 1'b0;
    if (abort_i) begin
      cnt_n  = '0;
      cnt_en = 1'b1;
    end else if (start_i) begin
      cnt_n  = len_i;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_n  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign done_o = (cnt_q == CW'(1));

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !abort_i && len_i != '0) |=> (cnt_q != '0));

endmodule

// File: rtl/page_buf.sv
module page_buf #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          fill_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_n [DEPTH];
  logic          mem_en;

  always_comb begin
    mem_n  = mem_q;
    mem_en = wr_en || fill_en;
    if (fill_en) begin
      for (int k = 0; k < DEPTH; k++) mem_n[k] = '1;
    end else if (wr_en) begin
      mem_n[wr_addr] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '1;
    end else if (mem_en) begin
      mem_q <= mem_n;
    end
  end

  assign rd_data = mem_q[rd_addr];

  // R9
  fill_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (mem_q[0] == '1 && mem_q[DEPTH-1] == '1));

endmodule

// File: rtl/nand_dev_if.sv
module nand_dev_if
  import nand_dev_pkg::*;
#(
  parameter int unsigned BUS_W         = 8,
  parameter int unsigned COL_W         = 4,
  parameter int unsigned PWRUP_CYC     = 20,
  parameter int unsigned RD_BUSY_CYC   = 8,
  parameter int unsigned PG_BUSY_CYC   = 12,
  parameter int unsigned ER_BUSY_CYC   = 16,
  parameter bit          SEL_DONT_CARE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             cmd_lat,
  input  logic             adr_lat,
  input  logic             wstb_n,
  input  logic             rstb_n,
  input  logic             guard_n,
  input  logic [BUS_W-1:0] bus_in,
  output logic [BUS_W-1:0] bus_out,
  output logic             bus_oe,
  output logic             ready
);

  localparam int unsigned TMR_MAX = max3(RD_BUSY_CYC, PG_BUSY_CYC, ER_BUSY_CYC);
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
  localparam int unsigned PW_W    = $clog2(PWRUP_CYC + 1);

  // synchronised strobe levels: 0 sel_n, 1 cmd_lat, 2 adr_lat, 3 wstb_n, 4 rstb_n, 5 guard_n
  logic [5:0] strb_s;

  strobe_sync #(.W(6), .RST_VAL(6'b011001)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({guard_n, rstb_n, wstb_n, adr_lat, cmd_lat, sel_n}),
    .sync_o (strb_s)
  );

  logic desel_s, cmd_s, adr_s, wstb_s, rstb_s, guard_s;
  assign desel_s = strb_s[0];
  assign cmd_s   = strb_s[1];
  assign adr_s   = strb_s[2];
  assign wstb_s  = strb_s[3];
  assign rstb_s  = strb_s[4];
  assign guard_s = strb_s[5];

  logic wstb_d_q, rstb_d_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wstb_d_q <= 1'b1;
      rstb_d_q <= 1'b1;
    end else begin
      wstb_d_q <= wstb_s;
      rstb_d_q <= rstb_s;
    end
  end

  logic wr_ev, rd_ev;
  assign wr_ev = wstb_s && !wstb_d_q;
  assign rd_ev = !rstb_s && rstb_d_q;

  // power-up recovery counter
  logic [PW_W-1:0] pwr_cnt_q;
  logic            pwr_ok;
  assign pwr_ok = (pwr_cnt_q == PW_W'(PWRUP_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pwr_cnt_q <= '0;
    else if (!pwr_ok) pwr_cnt_q <= pwr_cnt_q + 1'b1;
  end

  dev_state_e        st_q, st_n;
  logic [COL_W-1:0]  col_q, col_n;
  logic [BUS_W-1:0]  dout_q, dout_n;
  logic              oe_q, oe_n;
  logic              tmr_start, tmr_abort, tmr_done;
  logic [TMR_W-1:0]  tmr_len;
  logic              buf_wr, buf_fill;
  logic [BUS_W-1:0]  buf_rd;
  logic              is_busy, accept;
  logic [7:0]        op_byte;

  assign is_busy = (st_q == ST_RD_BUSY) || (st_q == ST_PG_BUSY) || (st_q == ST_ER_BUSY);
  assign accept  = wr_ev && !desel_s && pwr_ok && !is_busy;
  assign op_byte = bus_in[7:0];

  busy_timer #(.CW(TMR_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(tmr_start),
    .len_i  (tmr_len),
    .abort_i(tmr_abort),
    .done_o (tmr_done)
  );

  page_buf #(.DW(BUS_W), .AW(COL_W)) u_page (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (buf_wr),
    .wr_addr(col_q),
    .wr_data(bus_in),
    .fill_en(buf_fill),
    .rd_addr(col_q),
    .rd_data(buf_rd)
  );

  always_comb begin
    st_n      = st_q;
    col_n     = col_q;
    dout_n    = dout_q;
    tmr_start = 1'b0;
    tmr_abort = 1'b0;
    tmr_len   = '0;
    buf_wr    = 1'b0;
    buf_fill  = 1'b0;
    unique case (st_q)
      ST_RD_BUSY: begin
        if (desel_s && !SEL_DONT_CARE) begin
          st_n      = ST_IDLE;
          tmr_abort = 1'b1;
        end else if (tmr_done) begin
          st_n = ST_RD_OUT;
        end
      end
      ST_PG_BUSY: begin
        if (tmr_done) st_n = ST_IDLE;
      end
      ST_ER_BUSY: begin
        if (tmr_done) begin
          st_n     = ST_IDLE;
          buf_fill = 1'b1;
        end
      end
      default: begin
        if (accept && cmd_s && !adr_s) begin
          unique case (op_byte)
            OP_READ:  st_n = ST_RD_ADDR;
            OP_PROG: begin
              st_n  = guard_s ? ST_PG_LOAD : ST_IDLE;
              col_n = '0;
            end
            OP_PROG_GO: begin
              if (st_q == ST_PG_LOAD && guard_s) begin
                st_n      = ST_PG_BUSY;
                tmr_start = 1'b1;
                tmr_len   = TMR_W'(PG_BUSY_CYC);
              end else begin
                st_n = ST_IDLE;
              end
            end
            OP_ERASE: st_n = guard_s ? ST_ER_WAIT : ST_IDLE;
            OP_ERASE_GO: begin
              if (st_q == ST_ER_WAIT && guard_s) begin
                st_n      = ST_ER_BUSY;
                tmr_start = 1'b1;
                tmr_len   = TMR_W'(ER_BUSY_CYC);
              end else begin
                st_n = ST_IDLE;
              end
            end
            default:  st_n = ST_IDLE;
          endcase
        end else if (accept && adr_s && !cmd_s) begin
          col_n = bus_in[COL_W-1:0];
          if (st_q == ST_RD_ADDR) begin
            st_n      = ST_RD_BUSY;
            tmr_start = 1'b1;
            tmr_len   = TMR_W'(RD_BUSY_CYC);
          end
        end else if (accept && !adr_s && !cmd_s) begin
          if (st_q == ST_PG_LOAD) begin
            buf_wr = 1'b1;
            col_n  = col_q + 1'b1;
          end
        end else if (rd_ev && !desel_s && st_q == ST_RD_OUT) begin
          dout_n = buf_rd;
          col_n  = col_q + 1'b1;
        end
      end
    endcase
    oe_n = (st_n == ST_RD_OUT) && !desel_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      col_q  <= '0;
      dout_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      col_q  <= col_n;
      dout_q <= dout_n;
      oe_q   <= oe_n;
    end
  end

  assign bus_out = dout_q;
  assign bus_oe  = oe_q;
  assign ready   = !is_busy;

  // R4
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !bus_oe);

  // R5
  guard_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_s && !adr_s && !guard_s) |=>
      (st_q != ST_PG_LOAD && st_q != ST_PG_BUSY && st_q != ST_ER_WAIT && st_q != ST_ER_BUSY));

  // R6
  pe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_PG_BUSY || st_q == ST_ER_BUSY) && !tmr_done) |=> !ready);

  // R7
  rd_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RD_BUSY && desel_s && !SEL_DONT_CARE) |=> ready);

  // R8
  pwr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (st_q == ST_IDLE));

  // R2
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RD_OUT && rd_ev && !desel_s) |=> (col_q == COL_W'($past(col_q) + 1'b1)));

endmodule

// File: tb/nand_dev_if_bench.sv
module nand_dev_if_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BW = 8;

  // entries: {column[11:8], data[7:0]}
  localparam logic [11:0] VEC [0:5] = '{12'h0A5, 12'h13C, 12'h200, 12'hF81, 12'h77E, 12'h8C3};

  logic clk, rst_n, sel_n, cmd_lat, adr_lat, wstb_n, rstb_n, guard_n;
  logic [BW-1:0] bus_in;
  logic [BW-1:0] out_a, out_b;
  logic oe_a, oe_b, rdy_a, rdy_b;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] model [16];
  logic [7:0] rd_a, rd_b;
  logic       roe_a, roe_b;

  nand_dev_if #(.PWRUP_CYC(40), .RD_BUSY_CYC(16), .PG_BUSY_CYC(24), .ER_BUSY_CYC(16),
                .SEL_DONT_CARE(1'b0)) u_nand_dev_if (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .cmd_lat(cmd_lat), .adr_lat(adr_lat),
    .wstb_n(wstb_n), .rstb_n(rstb_n), .guard_n(guard_n), .bus_in(bus_in),
    .bus_out(out_a), .bus_oe(oe_a), .ready(rdy_a));

  nand_dev_if #(.PWRUP_CYC(40), .RD_BUSY_CYC(16), .PG_BUSY_CYC(24), .ER_BUSY_CYC(16),
                .SEL_DONT_CARE(1'b1)) u_nand_dev_if_dc (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .cmd_lat(cmd_lat), .adr_lat(adr_lat),
    .wstb_n(wstb_n), .rstb_n(rstb_n), .guard_n(guard_n), .bus_in(bus_in),
    .bus_out(out_b), .bus_oe(oe_b), .ready(rdy_b));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wcyc(input logic c, input logic a, input logic [7:0] d);
    cmd_lat = c; adr_lat = a; bus_in = d;
    repeat (4) @(negedge clk);
    wstb_n = 1'b0;
    repeat (4) @(negedge clk);
    wstb_n = 1'b1;
    repeat (4) @(negedge clk);
    cmd_lat = 1'b0; adr_lat = 1'b0;
  endtask

  task automatic op(input logic [7:0] d);  wcyc(1'b1, 1'b0, d); endtask
  task automatic adr(input logic [7:0] d); wcyc(1'b0, 1'b1, d); endtask
  task automatic dat(input logic [7:0] d); wcyc(1'b0, 1'b0, d); endtask

  task automatic rpulse();
    rstb_n = 1'b0;
    repeat (4) @(negedge clk);
    rd_a = out_a; rd_b = out_b; roe_a = oe_a; roe_b = oe_b;
    rstb_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_prog(input logic [3:0] col, input logic [7:0] d);
    op(8'h80); adr({4'h0, col}); dat(d); op(8'h10);
    repeat (40) @(negedge clk);
    model[col] = d;
  endtask

  task automatic do_read(input logic [3:0] col);
    op(8'h00); adr({4'h0, col});
    repeat (30) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) model[k] = 8'hFF;
    rst_n = 1'b0; sel_n = 1'b1; cmd_lat = 1'b0; adr_lat = 1'b0;
    wstb_n = 1'b1; rstb_n = 1'b1; guard_n = 1'b1; bus_in = '0;
    repeat (3) @(negedge clk);
    // R3 R4 reset state
    check(rdy_a == 1'b1, "R3 reset ready", rdy_a, 1);
    check(oe_a == 1'b0, "R4 reset oe", oe_a, 0);
    rst_n = 1'b1;
    sel_n = 1'b0;

    // R8: read opcode and address inside the recovery window are ignored
    op(8'h00); adr(8'h00);
    check(rdy_a == 1'b1, "R8 early bytes ignored", rdy_a, 1);
    repeat (30) @(negedge clk);

    // R1 table: program one word, read it back
    for (int i = 0; i < 6; i++) begin
      do_prog(VEC[i][11:8], VEC[i][7:0]);
      do_read(VEC[i][11:8]);
      rpulse();
      check(rd_a == VEC[i][7:0], "R1 program/read", rd_a, VEC[i][7:0]);
    end

    // R9 untouched column still erased
    do_read(4'd4); rpulse();
    check(rd_a == 8'hFF, "R9 reset page ones", rd_a, 8'hFF);

    // R2 sequential read
    do_read(4'd0);
    for (int j = 0; j < 3; j++) begin
      rpulse();
      check(rd_a == model[j], "R2 sequential", rd_a, model[j]);
      // R4 enable high during output
      if (j == 0) check(roe_a == 1'b1, "R4 oe in output", roe_a, 1);
    end
    sel_n = 1'b1;
    repeat (4) @(negedge clk);
    check(oe_a == 1'b0, "R4 oe off when deselected", oe_a, 0);
    sel_n = 1'b0;

    // R2 wrap
    do_read(4'd15);
    rpulse(); check(rd_a == model[15], "R2 last column", rd_a, model[15]);
    rpulse(); check(rd_a == model[0], "R2 wrap to 0", rd_a, model[0]);

    // R3 R6 program busy with deselect
    op(8'h80); adr(8'h03); dat(8'h66); op(8'h10);
    check(rdy_a == 1'b0, "R3 busy after confirm", rdy_a, 0);
    sel_n = 1'b1;
    repeat (6) @(negedge clk);
    check(rdy_a == 1'b0, "R6 deselect ignored", rdy_a, 0);
    repeat (30) @(negedge clk);
    check(rdy_a == 1'b1, "R3 ready after program", rdy_a, 1);
    sel_n = 1'b0;
    model[3] = 8'h66;
    do_read(4'd3); rpulse();
    check(rd_a == 8'h66, "R6 program completed", rd_a, 8'h66);

    // R5 guard blocks program
    guard_n = 1'b0;
    op(8'h80); adr(8'h03); dat(8'h99); op(8'h10);
    check(rdy_a == 1'b1, "R5 no program busy", rdy_a, 1);
    guard_n = 1'b1;
    do_read(4'd3); rpulse();
    check(rd_a == 8'h66, "R5 page unchanged", rd_a, 8'h66);
    // R5 guard blocks erase
    guard_n = 1'b0;
    op(8'h60); op(8'hD0);
    check(rdy_a == 1'b1, "R5 no erase busy", rdy_a, 1);
    guard_n = 1'b1;
    do_read(4'd0); rpulse();
    check(rd_a == model[0], "R5 erase rejected", rd_a, model[0]);

    // R7 deselect during read busy
    op(8'h00); adr(8'h05);
    check(rdy_a == 1'b0 && rdy_b == 1'b0, "R7 both busy", {rdy_a, rdy_b}, 0);
    sel_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rdy_a == 1'b1, "R7 read aborted", rdy_a, 1);
    check(rdy_b == 1'b0, "R7 dont-care keeps busy", rdy_b, 0);
    sel_n = 1'b0;
    repeat (30) @(negedge clk);
    rpulse();
    check(roe_a == 1'b0, "R7 aborted no output", roe_a, 0);
    check(rd_b == model[5] && roe_b == 1'b1, "R7 dont-care data", rd_b, model[5]);

    // R9 erase
    op(8'h60); op(8'hD0);
    check(rdy_a == 1'b0, "R3 erase busy", rdy_a, 0);
    repeat (40) @(negedge clk);
    for (int k = 0; k < 16; k++) model[k] = 8'hFF;
    do_read(4'd0);
    rpulse(); check(rd_a == 8'hFF, "R9 erased col0", rd_a, 8'hFF);
    rpulse(); check(rd_a == 8'hFF, "R9 erased col1", rd_a, 8'hFF);

    // R10 unknown opcode closes a program load
    op(8'h80); op(8'h33); dat(8'h12);
    do_read(4'd0); rpulse();
    check(rd_a == 8'hFF, "R10 load closed", rd_a, 8'hFF);
    // R10 program setup resets column to 0
    op(8'h80); dat(8'h4D); op(8'h10);
    repeat (40) @(negedge clk);
    do_read(4'd0); rpulse();
    check(rd_a == 8'h4D, "R10 column reset", rd_a, 8'h4D);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule